// File: doc/BRIEF.md
# ATA/ATAPI DMA Transfer Sequencer

This block runs a single drive DMA command whose data arrives as a series of chunks, each handed over by a DMA channel or reported back by the sector engine after an issued operation has finished. A start strobe loads the command: the media type (disk or optical), the command code, the sector count or packet byte size, and the starting sector or logical block. The sequencer keeps a signed count of bytes still owed and an index of bytes already moved. Each chunk event is sorted into one of six outcomes: error, stall, finish, segment end, non-block copy or block operation. The matching one-cycle pulse is driven on registered outputs.

A block operation reports the device byte offset, the chunk's memory address and length, and the operation kind. The sector engine carries the operation out and then presents the chunk again with length zero. A chunk that arrives while no command is active is answered with a stall pulse and nothing else, so the channel can wait and restart later. Optical commands whose logical block is all ones carry packet data that is not block addressed. These produce one copy request and end the command.

Top module: `xfer_seq`

## Requirements
- R1: A start strobe clears the byte index to 0 and sets the remaining count to sector count × 512 for a disk, or to the packet byte size for optical media. It sets `busy`, and on the next cycle `kick` is high and `status` is 0x80. When start and a chunk event occur in the same cycle, start wins and the event is dropped.
- R2: A chunk event with `ev_err` high ends the command. `dma_err`, `cmd_end` and `irq` pulse, `status` becomes 0x41 and `busy` clears. This takes priority over every other outcome, including an idle sequencer.
- R3: A chunk event without error while `busy` is low produces only a `stalled` pulse. `status` and the command state are left unchanged.
- R4: A chunk event while busy, with remaining count ≤ 0, pulses `cmd_end` and `irq`, sets `status` to 0x50 and clears `busy`. This outcome takes priority over the zero-length check.
- R5: A zero-length chunk event while busy with bytes still owed produces only `seg_done`. The command stays active and its counters are unchanged.
- R6: For a disk, an issued operation has `op_offset` = start sector × 512 + index, `op_len` = chunk length, `op_addr` = chunk address, and `op_kind` equal to the command code (read=0, write=1, trim=2, 3=other).
- R7: For optical media, `op_offset` = logical block × 2048 + index and `op_kind` is read (0). A disk whose sector is all ones still issues a block operation.
- R8: For optical media with a logical block of all ones, a non-zero chunk produces `copy_valid` with `copy_addr` = chunk address and `copy_len` = min(remaining, chunk length). It also pulses `cmd_end` and `irq`, sets `status` to 0x50 and clears `busy`.
- R9: Each issued operation lowers the remaining count by the chunk length and raises the index by the same amount. A chunk that overshoots drives the count below zero, and the command then ends at the next event.
- R10: At most one of `kick`, `op_valid`, `seg_done`, `stalled` and `cmd_end` is high in any cycle.
- R11: `irq` is a one-cycle pulse that comes only with `cmd_end`. `status` holds its value until the next start or command end.
- R12: At a command end, `acct_ok` (success) or `acct_fail` (error) pulses only for optical media or for disk commands read and write. Trim and other codes produce neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe for a new command |
| go_optical | input | 1 | 1 = optical media, 0 = disk |
| go_cmd | input | 2 | Command code: read=0, write=1, trim=2, other=3 |
| go_nsect | input | CNT_W | Disk sector count |
| go_pkt_bytes | input | PKT_W | Optical packet byte size |
| go_sector | input | SECT_W | Disk start sector |
| go_lba | input | SECT_W | Optical logical block (all ones = non-block data) |
| ev_valid | input | 1 | Chunk event present |
| ev_err | input | 1 | Chunk reports an error |
| ev_addr | input | ADDR_W | Chunk memory address |
| ev_len | input | LEN_W | Chunk length in bytes |
| kick | output | 1 | Pulse asking the channel to run |
| busy | output | 1 | Command active flag |
| seg_done | output | 1 | Pulse: current DMA segment ended |
| stalled | output | 1 | Pulse: chunk arrived with no active command |
| op_valid | output | 1 | Pulse: block operation issued |
| op_kind | output | 2 | Operation code of the issued operation |
| op_offset | output | OFS_W | Device byte offset of the operation |
| op_len | output | LEN_W | Operation length in bytes |
| op_addr | output | ADDR_W | Memory address of the operation |
| copy_valid | output | 1 | Pulse: non-block copy requested |
| copy_addr | output | ADDR_W | Copy destination address |
| copy_len | output | LEN_W | Copy length in bytes |
| cmd_end | output | 1 | Pulse: command finished |
| dma_err | output | 1 | Pulse: command ended on error |
| acct_ok | output | 1 | Pulse: success accounted |
| acct_fail | output | 1 | Pulse: failure accounted |
| irq | output | 1 | Interrupt pulse |
| status | output | 8 | Drive status byte |

## Verification
The bench sweeps every command code against sector counts from zero to seven, three start sectors including all ones, and chunk sizes that divide the transfer evenly or overshoot it. A design that tested the zero-length chunk before the remaining count would never finish a command, and one that treated the all-ones disk sector as packet data would copy instead of issue. Optical transfers check the ×2048 scaling and the min() clamp on non-block copies, where a wrong clamp shows as an oversized `copy_len`. Errors raised mid-transfer, from an idle sequencer and on trim check the error priority and the accounting gate, and a start colliding with an event checks that the event is dropped.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

   typedef enum logic [1:0] {
      CMD_READ  = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_TRIM  = 2'd2,
      CMD_OTHER = 2'd3
   } cmd_e;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_FAIL,
      ACT_STALL,
      ACT_FINISH,
      ACT_SEGEND,
      ACT_COPY,
      ACT_ISSUE
   } act_e;

   localparam logic [7:0] ST_BUSY = 8'h80;
   localparam logic [7:0] ST_DONE = 8'h50;
   localparam logic [7:0] ST_ERR  = 8'h41;

   localparam int DISK_SHIFT = 9;
   localparam int OPT_SHIFT  = 11;

endpackage

// File: rtl/xfer_seq_track.sv
module xfer_seq_track
   import xfer_seq_pkg::*;
#(
   parameter int CNT_W  = 3,
   parameter int PKT_W  = 12,
   parameter int LEN_W  = 12,
   parameter int SECT_W = 5,
   parameter int REM_W  = 14
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     ld_optical,
   input  logic [1:0]               ld_cmd,
   input  logic [CNT_W-1:0]         ld_nsect,
   input  logic [PKT_W-1:0]         ld_pkt,
   input  logic [SECT_W-1:0]        ld_sector,
   input  logic [SECT_W-1:0]        ld_lba,
   input  logic                     advance,
   input  logic                     finish,
   input  logic [LEN_W-1:0]         step_len,
   output logic                     busy,
   output logic                     optical,
   output logic [1:0]               cmd,
   output logic [SECT_W-1:0]        sector,
   output logic [SECT_W-1:0]        lba,
   output logic signed [REM_W-1:0]  rem,
   output logic [REM_W-1:0]         idx
);

   localparam int DISK_BYTES_W = CNT_W + DISK_SHIFT;

   logic signed [REM_W-1:0] step_ext;
   logic signed [REM_W-1:0] load_rem;

   assign step_ext = $signed({{(REM_W-LEN_W){1'b0}}, step_len});

   always_comb begin
      if (ld_optical)
         load_rem = $signed({{(REM_W-PKT_W){1'b0}}, ld_pkt});
      else
         load_rem = $signed({{(REM_W-DISK_BYTES_W){1'b0}}, ld_nsect, {DISK_SHIFT{1'b0}}});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         optical <= 1'b0;
         cmd     <= CMD_READ;
         sector  <= '0;
         lba     <= '0;
         rem     <= '0;
         idx     <= '0;
      end else if (load) begin
         busy    <= 1'b1;
         optical <= ld_optical;
         cmd     <= ld_cmd;
         sector  <= ld_sector;
         lba     <= ld_lba;
         rem     <= load_rem;
         idx     <= '0;
      end else begin
         if (advance) begin
            rem <= rem - step_ext;
            idx <= idx + $unsigned(step_ext);
         end
         if (finish)
            busy <= 1'b0;
      end
   end

endmodule

// File: rtl/xfer_seq_decide.sv
module xfer_seq_decide
   import xfer_seq_pkg::*;
#(
   parameter int LEN_W  = 12,
   parameter int SECT_W = 5,
   parameter int REM_W  = 14
) (
   input  logic                    ev_valid,
   input  logic                    ev_err,
   input  logic [LEN_W-1:0]        ev_len,
   input  logic                    busy,
   input  logic                    optical,
   input  logic [SECT_W-1:0]       lba,
   input  logic signed [REM_W-1:0] rem,
   output act_e                    act
);

   always_comb begin
      act = ACT_NONE;
      if (ev_valid) begin
         if (ev_err)
            act = ACT_FAIL;
         else if (!busy)
            act = ACT_STALL;
         else if (rem <= 0)
            act = ACT_FINISH;
         else if (ev_len == '0)
            act = ACT_SEGEND;
         else if (optical && (&lba))
            act = ACT_COPY;
         else
            act = ACT_ISSUE;
      end
   end

endmodule

// File: rtl/xfer_seq_offset.sv
module xfer_seq_offset
   import xfer_seq_pkg::*;
#(
   parameter int SECT_W = 5,
   parameter int REM_W  = 14,
   parameter int OFS_W  = 17
) (
   input  logic              optical,
   input  logic [SECT_W-1:0] sector,
   input  logic [SECT_W-1:0] lba,
   input  logic [REM_W-1:0]  idx,
   output logic [OFS_W-1:0]  offset
);

   logic [OFS_W-1:0] cand [2];

   for (genvar m = 0; m < 2; m++) begin : g_media
      localparam int SH = (m == 0) ? DISK_SHIFT : OPT_SHIFT;
      logic [SECT_W-1:0] base;
      assign base    = (m == 0) ? sector : lba;
      assign cand[m] = ({{(OFS_W-SECT_W){1'b0}}, base} << SH)
                     + {{(OFS_W-REM_W){1'b0}}, idx};
   end

   assign offset = optical ? cand[1] : cand[0];

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
   import xfer_seq_pkg::*;
#(
   parameter int CNT_W  = 3,
   parameter int PKT_W  = 12,
   parameter int LEN_W  = 12,
   parameter int SECT_W = 5,
   parameter int ADDR_W = 16,
   localparam int MAX_A = ((CNT_W + 9) > PKT_W) ? (CNT_W + 9) : PKT_W,
   localparam int MAX_B = (MAX_A > LEN_W) ? MAX_A : LEN_W,
   localparam int REM_W = MAX_B + 2,
   localparam int OFS_W = (((SECT_W + 11) > REM_W) ? (SECT_W + 11) : REM_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_optical,
   input  logic [1:0]        go_cmd,
   input  logic [CNT_W-1:0]  go_nsect,
   input  logic [PKT_W-1:0]  go_pkt_bytes,
   input  logic [SECT_W-1:0] go_sector,
   input  logic [SECT_W-1:0] go_lba,
   input  logic              ev_valid,
   input  logic              ev_err,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [LEN_W-1:0]  ev_len,
   output logic              kick,
   output logic              busy,
   output logic              seg_done,
   output logic              stalled,
   output logic              op_valid,
   output logic [1:0]        op_kind,
   output logic [OFS_W-1:0]  op_offset,
   output logic [LEN_W-1:0]  op_len,
   output logic [ADDR_W-1:0] op_addr,
   output logic              copy_valid,
   output logic [ADDR_W-1:0] copy_addr,
   output logic [LEN_W-1:0]  copy_len,
   output logic              cmd_end,
   output logic              dma_err,
   output logic              acct_ok,
   output logic              acct_fail,
   output logic              irq,
   output logic [7:0]        status
);

   if (CNT_W < 1 || PKT_W < 1 || LEN_W < 2 || SECT_W < 2 || ADDR_W < 1) begin : g_bad_cfg
      $error("xfer_seq: width parameter out of range");
   end

   logic                    t_optical;
   logic [1:0]              t_cmd;
   logic [SECT_W-1:0]       t_sector;
   logic [SECT_W-1:0]       t_lba;
   logic signed [REM_W-1:0] t_rem;
   logic [REM_W-1:0]        t_idx;
   logic [OFS_W-1:0]        cur_offset;
   act_e                    act;
   logic                    acct_en;
   logic                    do_finish;
   logic                    do_advance;
   logic signed [REM_W-1:0] len_s;
   logic [LEN_W-1:0]        clamp_len;

   xfer_seq_track #(
      .CNT_W(CNT_W), .PKT_W(PKT_W), .LEN_W(LEN_W), .SECT_W(SECT_W), .REM_W(REM_W)
   ) u_track (
      .clk(clk), .rst_n(rst_n),
      .load(go), .ld_optical(go_optical), .ld_cmd(go_cmd), .ld_nsect(go_nsect),
      .ld_pkt(go_pkt_bytes), .ld_sector(go_sector), .ld_lba(go_lba),
      .advance(do_advance), .finish(do_finish), .step_len(ev_len),
      .busy(busy), .optical(t_optical), .cmd(t_cmd), .sector(t_sector),
      .lba(t_lba), .rem(t_rem), .idx(t_idx)
   );

   xfer_seq_decide #(
      .LEN_W(LEN_W), .SECT_W(SECT_W), .REM_W(REM_W)
   ) u_decide (
      .ev_valid(ev_valid && !go), .ev_err(ev_err), .ev_len(ev_len),
      .busy(busy), .optical(t_optical), .lba(t_lba), .rem(t_rem), .act(act)
   );

   xfer_seq_offset #(
      .SECT_W(SECT_W), .REM_W(REM_W), .OFS_W(OFS_W)
   ) u_offset (
      .optical(t_optical), .sector(t_sector), .lba(t_lba), .idx(t_idx),
      .offset(cur_offset)
   );

   assign acct_en    = t_optical || (t_cmd == CMD_READ) || (t_cmd == CMD_WRITE);
   assign do_finish  = (act == ACT_FAIL) || (act == ACT_FINISH) || (act == ACT_COPY);
   assign do_advance = (act == ACT_ISSUE);
   assign len_s      = $signed({{(REM_W-LEN_W){1'b0}}, ev_len});
   assign clamp_len  = (t_rem < len_s) ? t_rem[LEN_W-1:0] : ev_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kick       <= 1'b0;
         seg_done   <= 1'b0;
         stalled    <= 1'b0;
         op_valid   <= 1'b0;
         op_kind    <= CMD_READ;
         op_offset  <= '0;
         op_len     <= '0;
         op_addr    <= '0;
         copy_valid <= 1'b0;
         copy_addr  <= '0;
         copy_len   <= '0;
         cmd_end    <= 1'b0;
         dma_err    <= 1'b0;
         acct_ok    <= 1'b0;
         acct_fail  <= 1'b0;
         irq        <= 1'b0;
         status     <= '0;
      end else begin
         kick       <= 1'b0;
         seg_done   <= 1'b0;
         stalled    <= 1'b0;
         op_valid   <= 1'b0;
         copy_valid <= 1'b0;
         cmd_end    <= 1'b0;
         dma_err    <= 1'b0;
         acct_ok    <= 1'b0;
         acct_fail  <= 1'b0;
         irq        <= 1'b0;
         if (go) begin
            kick   <= 1'b1;
            status <= ST_BUSY;
         end else begin
            unique case (act)
               ACT_FAIL: begin
                  dma_err   <= 1'b1;
                  cmd_end   <= 1'b1;
                  irq       <= 1'b1;
                  acct_fail <= acct_en;
                  status    <= ST_ERR;
               end
               ACT_STALL:  stalled  <= 1'b1;
               ACT_SEGEND: seg_done <= 1'b1;
               ACT_FINISH: begin
                  cmd_end <= 1'b1;
                  irq     <= 1'b1;
                  acct_ok <= acct_en;
                  status  <= ST_DONE;
               end
               ACT_COPY: begin
                  copy_valid <= 1'b1;
                  copy_addr  <= ev_addr;
                  copy_len   <= clamp_len;
                  cmd_end    <= 1'b1;
                  irq        <= 1'b1;
                  acct_ok    <= acct_en;
                  status     <= ST_DONE;
               end
               ACT_ISSUE: begin
                  op_valid  <= 1'b1;
                  op_kind   <= t_optical ? CMD_READ : t_cmd;
                  op_offset <= cur_offset;
                  op_len    <= ev_len;
                  op_addr   <= ev_addr;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
   parameter int LEN_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic [LEN_W-1:0] ev_len,
   input logic             kick,
   input logic             busy,
   input logic             seg_done,
   input logic             stalled,
   input logic             op_valid,
   input logic [LEN_W-1:0] op_len,
   input logic             copy_valid,
   input logic [LEN_W-1:0] copy_len,
   input logic             cmd_end,
   input logic             dma_err,
   input logic             irq,
   input logic [7:0]       status
);

   assert_kick_after_go_R1: assert property (@(posedge clk) disable iff (!rst_n)
      kick |-> (busy && status == 8'h80 && $past(go)));

   assert_err_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dma_err |-> (cmd_end && !busy && status == 8'h41));

   assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |-> (!busy && !irq && $stable(status)));

   assert_end_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_end |-> !busy);

   assert_op_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> (busy && op_len != '0));

   assert_copy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      copy_valid |-> (cmd_end && copy_len != '0 && copy_len <= $past(ev_len)));

   assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({kick, op_valid, seg_done, stalled, cmd_end}));

   assert_irq_with_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cmd_end);

   assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!kick && !cmd_end) |-> $stable(status));

endmodule

bind xfer_seq xfer_seq_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .ev_len(ev_len),
   .kick(kick), .busy(busy), .seg_done(seg_done), .stalled(stalled),
   .op_valid(op_valid), .op_len(op_len), .copy_valid(copy_valid),
   .copy_len(copy_len), .cmd_end(cmd_end), .dma_err(dma_err),
   .irq(irq), .status(status)
);

// File: tb/xfer_seq_test.sv
module xfer_seq_test;
   localparam int CNT_W = 3, PKT_W = 12, LEN_W = 12, SECT_W = 5, ADDR_W = 16;
   localparam int OFS_W = 17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              go = 0, go_optical = 0;
   logic [1:0]        go_cmd = 0;
   logic [CNT_W-1:0]  go_nsect = 0;
   logic [PKT_W-1:0]  go_pkt_bytes = 0;
   logic [SECT_W-1:0] go_sector = 0, go_lba = 0;
   logic              ev_valid = 0, ev_err = 0;
   logic [ADDR_W-1:0] ev_addr = 0;
   logic [LEN_W-1:0]  ev_len = 0;
   logic kick, busy, seg_done, stalled, op_valid, copy_valid;
   logic cmd_end, dma_err, acct_ok, acct_fail, irq;
   logic [1:0]        op_kind;
   logic [OFS_W-1:0]  op_offset;
   logic [LEN_W-1:0]  op_len, copy_len;
   logic [ADDR_W-1:0] op_addr, copy_addr;
   logic [7:0]        status;

   xfer_seq uut (.*);

   int total = 0, bad = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [18:0] snap();
      return {kick, seg_done, stalled, op_valid, copy_valid, cmd_end, dma_err,
              acct_ok, acct_fail, irq, busy, status};
   endfunction

   function automatic logic [18:0] ex(bit k, bit sd, bit st, bit op, bit cp, bit ce,
                                      bit de, bit ao, bit af, bit iq, bit bz, logic [7:0] s);
      return {k, sd, st, op, cp, ce, de, ao, af, iq, bz, s};
   endfunction

   task automatic start(bit opt, int cmd, int nsect, int pkt, int sect, int lba);
      @(negedge clk);
      go = 1; go_optical = opt; go_cmd = 2'(cmd); go_nsect = CNT_W'(nsect);
      go_pkt_bytes = PKT_W'(pkt); go_sector = SECT_W'(sect); go_lba = SECT_W'(lba);
      @(posedge clk); #1;
      go = 0;
   endtask

   task automatic event_in(bit err, int len, int addr);
      @(negedge clk);
      ev_valid = 1; ev_err = err; ev_len = LEN_W'(len); ev_addr = ADDR_W'(addr);
      @(posedge clk); #1;
      ev_valid = 0; ev_err = 0;
   endtask

   task automatic idle_cycle();
      @(posedge clk); #1;
   endtask

   // block transfer walk: chunks of len until the remaining count is spent
   task automatic run_block(bit opt, int cmd, int nsect, int pkt, int base, int len);
      int rem = opt ? pkt : nsect * 512;
      int idx = 0;
      int scale = opt ? 2048 : 512;
      bit acc = opt || (cmd < 2);
      start(opt, cmd, nsect, pkt, opt ? 0 : base, opt ? base : 0);
      chk("R1 start", snap(), ex(1,0,0,0,0,0,0,0,0,0,1,8'h80));
      forever begin
         event_in(0, len, 16'h100 + idx);
         if (rem <= 0) begin
            chk("R4 finish", snap(), ex(0,0,0,0,0,1,0,acc,0,1,0,8'h50));
            break;
         end
         chk("R6 R7 issue", snap(), ex(0,0,0,1,0,0,0,0,0,0,1,8'h80));
         chk(opt ? "R7 offset" : "R6 offset", 64'(op_offset), 64'(base * scale + idx));
         chk("R6 kind", 64'(op_kind), 64'(opt ? 0 : cmd));
         chk("R6 len/addr", {op_len, op_addr}, {LEN_W'(len), ADDR_W'(16'h100 + idx)});
         idx += len;
         rem -= len;
         event_in(0, 0, 0);
         if (rem <= 0) begin
            chk("R9 R4 finish", snap(), ex(0,0,0,0,0,1,0,acc,0,1,0,8'h50));
            break;
         end
         chk("R5 segend", snap(), ex(0,1,0,0,0,0,0,0,0,0,1,8'h80));
      end
      idle_cycle();
      chk("R11 hold", snap(), ex(0,0,0,0,0,0,0,0,0,0,0,8'h50));
      event_in(0, 256, 0);
      chk("R3 stall", snap(), ex(0,0,1,0,0,0,0,0,0,0,0,8'h50));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset", snap(), 19'h0);
      @(negedge clk); rst_n = 1;
      idle_cycle();
      chk("R1 after reset", snap(), 19'h0);

      // disk sweep: every command, sector counts 0..7, sectors incl. all ones
      for (int c = 0; c < 4; c++)
         for (int n = 0; n < 8; n++)
            for (int si = 0; si < 3; si++)
               for (int li = 0; li < 3; li++)
                  run_block(0, c, n, 0, (si == 0) ? 0 : (si == 1) ? 1 : 31,
                            (li == 0) ? 512 : (li == 1) ? 1024 : 768);

      // optical block sweep
      for (int bi = 0; bi < 3; bi++)
         for (int pi = 0; pi < 4; pi++)
            for (int li = 0; li < 2; li++)
               run_block(1, 3, 0, (pi == 0) ? 1 : (pi == 1) ? 2048 : (pi == 2) ? 3000 : 4095,
                         (bi == 0) ? 0 : (bi == 1) ? 5 : 30, (li == 0) ? 2048 : 1000);

      // optical non-block copy with clamp
      for (int pi = 0; pi < 3; pi++)
         for (int li = 0; li < 3; li++) begin
            int pkt = (pi == 0) ? 100 : (pi == 1) ? 2048 : 4000;
            int len = (li == 0) ? 50 : (li == 1) ? 2048 : 4095;
            start(1, 1, 0, pkt, 0, 31);
            event_in(0, len, 16'h4000 + pi * 16 + li);
            chk("R8 copy", snap(), ex(0,0,0,0,1,1,0,1,0,1,0,8'h50));
            chk("R8 copy len", 64'(copy_len), 64'((pkt < len) ? pkt : len));
            chk("R8 copy addr", 64'(copy_addr), 64'(16'h4000 + pi * 16 + li));
         end

      // errors
      start(0, 0, 4, 0, 3, 0);
      event_in(0, 512, 0);
      chk("R6 before err", snap(), ex(0,0,0,1,0,0,0,0,0,0,1,8'h80));
      event_in(1, 0, 0);
      chk("R2 read err", snap(), ex(0,0,0,0,0,1,1,0,1,1,0,8'h41));
      start(0, 2, 2, 0, 0, 0);
      event_in(1, 512, 0);
      chk("R2 R12 trim err", snap(), ex(0,0,0,0,0,1,1,0,0,1,0,8'h41));
      event_in(1, 512, 0);
      chk("R2 R10 idle err", snap(), ex(0,0,0,0,0,1,1,0,0,1,0,8'h41));
      start(1, 0, 0, 500, 0, 31);
      event_in(1, 100, 0);
      chk("R2 optical err", snap(), ex(0,0,0,0,0,1,1,0,1,1,0,8'h41));

      // start and event in the same cycle: event dropped
      @(negedge clk);
      go = 1; go_optical = 0; go_cmd = 2'd1; go_nsect = 3'd2; go_sector = 5'd7;
      ev_valid = 1; ev_err = 0; ev_len = 12'd512; ev_addr = 16'h55;
      @(posedge clk); #1;
      go = 0; ev_valid = 0;
      chk("R1 R10 go wins", snap(), ex(1,0,0,0,0,0,0,0,0,0,1,8'h80));
      event_in(0, 0, 0);
      chk("R5 early segend", snap(), ex(0,1,0,0,0,0,0,0,0,0,1,8'h80));
      event_in(0, 512, 0);
      chk("R9 index untouched", 64'(op_offset), 64'(7 * 512));
      chk("R6 write kind", 64'(op_kind), 64'(1));

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule